// File: doc/BRIEF.md
# Doorbell Interrupt Register File

This block is the register slave of a shared-memory doorbell device that links several nodes. Software sees a 256-byte register window with four 32-bit words: an interrupt enable mask, an interrupt status word that clears when it is read, a read-only identifier for this node, and a doorbell word. A write to the doorbell names a destination peer and a vector. The block checks the pair against a per-peer table of registered vector counts. If the pair is valid, it issues a single-cycle notify strobe that carries the peer and the vector.

In legacy mode the block drives a level interrupt line, which is high while status AND mask is nonzero. An event arriving on one of this node's own vectors loads the value 1 into the status word. When message-signalled mode is selected, or when the interrupt pin is marked unused, the line is held low. Configuration logic fills the vector-count table through a dedicated load port. The peer count is a parameter.

Top module: `dbell_regfile`

## Requirements
- R1: After reset the mask, status, read data, interrupt line and notify strobe are all zero, and every peer's vector count is zero.
- R2: Word 0 (byte offset 0) holds the mask and word 1 (byte offset 4) holds the status. A write stores the full 32-bit data, and on writes the two low address bits are ignored (offset 0x05 writes the status).
- R3: A read of offset 4 returns the status value and clears the status to zero at that same access. A second read returns zero and the interrupt line falls.
- R4: The interrupt line is high exactly when (status AND mask) is nonzero, message-signalled mode is off and the pin is in use. Otherwise it is low.
- R5: Read data appears one cycle after the read strobe, together with a one-cycle valid. Offset 8 returns the node identifier in bits 15:0 with zeros above. Every other address returns zero: offset 12, addresses outside the 16-byte register block, and any address whose two low bits are nonzero. A read of offset 0x05 does not clear the status.
- R6: Writes to offset 8 or to addresses outside the register block leave the mask and the status unchanged.
- R7: A doorbell write at word 3 (byte offset 12, low address bits ignored) takes the destination peer from data bits 31:16 and the vector from data bits 7:0. Bits 15:8 are ignored. A valid doorbell raises notify_valid for exactly the cycle after the write, with notify_peer and notify_vector set to the decoded fields.
- R8: A doorbell is dropped, with no strobe, when the destination is not below the peer count or the vector is not below the count loaded for that peer. Counts are loaded through the config port (peer index, 9-bit count 0..256).
- R9: In legacy mode a local event pulse loads the status with the value 1, replacing its contents. In message-signalled mode the event leaves the status untouched.
- R10: In a single cycle a legacy local event takes priority over a bus write to the status and over the clear caused by a status read. That read still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | ADDR_W | Byte address in the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| rdata_valid | output | 1 | Marks the cycle that rdata answers a read |
| node_id | input | 16 | This node's identifier, read at offset 8 |
| msi_mode | input | 1 | Selects message-signalled interrupts, which gates the line off |
| pin_used | input | 1 | Interrupt pin in use for legacy signalling |
| local_event | input | 1 | Pulse for an incoming event on an own vector |
| cfg_wr | input | 1 | Loads a peer's vector count |
| cfg_peer | input | PEER_W | Peer index for the count load |
| cfg_count | input | CNT_W | Number of vectors registered for that peer |
| irq | output | 1 | Level interrupt line |
| notify_valid | output | 1 | One-cycle strobe for an accepted doorbell |
| notify_peer | output | PEER_W | Destination peer of the accepted doorbell |
| notify_vector | output | 8 | Vector of the accepted doorbell |

## Verification
The properties assume that rd_en and wr_en are never high in the same cycle. They also assume that cfg_peer always indexes an existing peer and that cfg_count never exceeds 256. Each directed task issues exactly one bus access per cycle, never raises both strobes together, and draws its config loads only from peers 0 to 15 with counts within range. Local events are raised only inside a bus write or read cycle, or in a cycle with no bus activity. This keeps the priority case for status alone and clear of the assumptions above.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DATA_W  = 32;
  localparam int ID_W    = 16;
  localparam int VEC_W   = 8;
  localparam int DEST_LO = 16;

  typedef enum logic [1:0] {
    SLOT_MASK = 2'd0,
    SLOT_STAT = 2'd1,
    SLOT_POS  = 2'd2,
    SLOT_RING = 2'd3
  } slot_e;

  typedef struct packed {
    logic wr_mask;
    logic wr_stat;
    logic wr_ring;
    logic rd_mask;
    logic rd_stat;
    logic rd_pos;
  } acc_t;
endpackage

// File: rtl/dbell_rst_sync.sv
module dbell_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);
  logic  in_block;
  logic  aligned;
  slot_e slot;

  always_comb begin
    in_block = (addr[ADDR_W-1:4] == '0);
    aligned  = (addr[1:0] == 2'b00);
    slot     = slot_e'(addr[3:2]);
    acc      = '0;
    // writes drop the two low address bits before decode
    if (wr_en && in_block) begin
      acc.wr_mask = (slot == SLOT_MASK);
      acc.wr_stat = (slot == SLOT_STAT);
      acc.wr_ring = (slot == SLOT_RING);
    end
    // reads decode the full address; anything unaligned misses
    if (rd_en && in_block && aligned) begin
      acc.rd_mask = (slot == SLOT_MASK);
      acc.rd_stat = (slot == SLOT_STAT);
      acc.rd_pos  = (slot == SLOT_POS);
    end
  end
endmodule

// File: rtl/dbell_irq_regs.sv
module dbell_irq_regs
  import dbell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_clr,
  input  logic              evt_set,
  input  logic              legacy_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq
);
  logic [DATA_W-1:0] mask_d;
  logic [DATA_W-1:0] stat_d;
  logic              mask_en;
  logic              stat_en;

  always_comb begin
    mask_en = wr_mask;
    mask_d  = wdata;
    stat_en = evt_set | wr_stat | rd_clr;
    // event beats bus write, bus write beats read-clear
    if (evt_set)      stat_d = DATA_W'(1);
    else if (wr_stat) stat_d = wdata;
    else              stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign irq = legacy_en & (|(stat_q & mask_q));
endmodule

// File: rtl/dbell_vec_table.sv
module dbell_vec_table
  import dbell_pkg::*;
#(
  parameter  int PEERS  = 16,
  parameter  int CNT_W  = 9,
  localparam int PEER_W = $clog2(PEERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [PEER_W-1:0] cfg_peer,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ID_W-1:0]   look_peer,
  output logic              look_ok,
  output logic [CNT_W-1:0]  look_count
);
  logic [PEERS-1:0][CNT_W-1:0] tbl;

  for (genvar g = 0; g < PEERS; g++) begin : g_entry
    logic             ent_en;
    logic [CNT_W-1:0] ent_q;

    assign ent_en = cfg_wr && (cfg_peer == PEER_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= cfg_count;
    end

    assign tbl[g] = ent_q;
  end

  always_comb begin
    look_ok    = (32'(look_peer) < PEERS);
    look_count = '0;
    for (int i = 0; i < PEERS; i++) begin
      if (look_peer == ID_W'(i)) look_count = tbl[i];
    end
  end
endmodule

// File: rtl/dbell_ring_check.sv
module dbell_ring_check
  import dbell_pkg::*;
#(
  parameter  int PEERS  = 16,
  parameter  int CNT_W  = 9,
  localparam int PEER_W = $clog2(PEERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_wr,
  input  logic [ID_W-1:0]   dest,
  input  logic [VEC_W-1:0]  vec,
  input  logic              peer_ok,
  input  logic [CNT_W-1:0]  count,
  output logic              notify_valid,
  output logic [PEER_W-1:0] notify_peer,
  output logic [VEC_W-1:0]  notify_vector
);
  logic accept;

  always_comb accept = ring_wr && peer_ok && (CNT_W'(vec) < count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) notify_valid <= 1'b0;
    else        notify_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_peer   <= '0;
      notify_vector <= '0;
    end else if (accept) begin
      notify_peer   <= dest[PEER_W-1:0];
      notify_vector <= vec;
    end
  end
endmodule

// File: rtl/dbell_regfile.sv
module dbell_regfile
  import dbell_pkg::*;
#(
  parameter  int PEERS  = 16,
  parameter  int ADDR_W = 8,
  parameter  int CNT_W  = 9,
  localparam int PEER_W = $clog2(PEERS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rdata_valid,
  input  logic [15:0]       node_id,
  input  logic              msi_mode,
  input  logic              pin_used,
  input  logic              local_event,
  input  logic              cfg_wr,
  input  logic [PEER_W-1:0] cfg_peer,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              irq,
  output logic              notify_valid,
  output logic [PEER_W-1:0] notify_peer,
  output logic [7:0]        notify_vector
);
  logic              rst_sync_n;
  acc_t              acc;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_q;
  logic              evt_set;
  logic              legacy_en;
  logic              peer_ok;
  logic [CNT_W-1:0]  peer_count;
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;

  dbell_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (addr),
    .acc   (acc)
  );

  assign evt_set   = local_event & ~msi_mode;
  assign legacy_en = ~msi_mode & pin_used;

  dbell_irq_regs u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_mask   (acc.wr_mask),
    .wr_stat   (acc.wr_stat),
    .rd_clr    (acc.rd_stat),
    .evt_set   (evt_set),
    .legacy_en (legacy_en),
    .wdata     (wdata),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .irq       (irq)
  );

  dbell_vec_table #(.PEERS(PEERS), .CNT_W(CNT_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_wr     (cfg_wr),
    .cfg_peer   (cfg_peer),
    .cfg_count  (cfg_count),
    .look_peer  (wdata[31:DEST_LO]),
    .look_ok    (peer_ok),
    .look_count (peer_count)
  );

  dbell_ring_check #(.PEERS(PEERS), .CNT_W(CNT_W)) u_ring (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .ring_wr       (acc.wr_ring),
    .dest          (wdata[31:DEST_LO]),
    .vec           (wdata[VEC_W-1:0]),
    .peer_ok       (peer_ok),
    .count         (peer_count),
    .notify_valid  (notify_valid),
    .notify_peer   (notify_peer),
    .notify_vector (notify_vector)
  );

  always_comb begin
    rdata_en = rd_en;
    if (acc.rd_mask)      rdata_d = mask_q;
    else if (acc.rd_stat) rdata_d = stat_q;
    else if (acc.rd_pos)  rdata_d = {{(DATA_W-ID_W){1'b0}}, node_id};
    else                  rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   rdata <= '0;
    else if (rdata_en) rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_valid <= 1'b0;
    else             rdata_valid <= rd_en;
  end
endmodule

// File: rtl/dbell_regfile_chk.sv
module dbell_regfile_chk #(
  parameter  int PEERS  = 16,
  parameter  int ADDR_W = 8,
  localparam int PEER_W = $clog2(PEERS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        vec_in,
  input logic [31:0]       rdata,
  input logic              rdata_valid,
  input logic              msi_mode,
  input logic              pin_used,
  input logic              local_event,
  input logic              irq,
  input logic              notify_valid,
  input logic [7:0]        notify_vector,
  input logic [31:0]       mask_q,
  input logic [31:0]       stat_q
);
  logic stat_rd_plain;
  assign stat_rd_plain = rd_en && !wr_en && (addr == ADDR_W'(4)) &&
                         !(local_event && !msi_mode);

  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_mode || !pin_used) |-> !irq);

  assert_stat_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_plain |=> (stat_q == 32'd0));

  assert_stat_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_plain |=> (rdata == $past(stat_q)));

  assert_event_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (local_event && !msi_mode) |=> (stat_q == 32'd1));

  assert_notify_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> ($past(wr_en) && ($past(addr[ADDR_W-1:2]) == (ADDR_W-2)'(3))
                      && ($past(vec_in) == notify_vector)));

  assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(rd_en));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr[ADDR_W-1:2] == '0)) |=> $stable(mask_q));
endmodule

bind dbell_regfile dbell_regfile_chk #(.PEERS(PEERS), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .addr          (addr),
  .vec_in        (wdata[7:0]),
  .rdata         (rdata),
  .rdata_valid   (rdata_valid),
  .msi_mode      (msi_mode),
  .pin_used      (pin_used),
  .local_event   (local_event),
  .irq           (irq),
  .notify_valid  (notify_valid),
  .notify_vector (notify_vector),
  .mask_q        (mask_q),
  .stat_q        (stat_q)
);

// File: tb/dbell_regfile_test.sv
`timescale 1ns/1ps
module dbell_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int PEERS  = 16;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 9;
  localparam int PEER_W = $clog2(PEERS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_en, wr_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata, rdata;
  logic              rdata_valid;
  logic [15:0]       node_id;
  logic              msi_mode, pin_used, local_event;
  logic              cfg_wr;
  logic [PEER_W-1:0] cfg_peer;
  logic [CNT_W-1:0]  cfg_count;
  logic              irq, notify_valid;
  logic [PEER_W-1:0] notify_peer;
  logic [7:0]        notify_vector;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_regfile #(.PEERS(PEERS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid), .node_id(node_id),
    .msi_mode(msi_mode), .pin_used(pin_used), .local_event(local_event),
    .cfg_wr(cfg_wr), .cfg_peer(cfg_peer), .cfg_count(cfg_count), .irq(irq),
    .notify_valid(notify_valid), .notify_peer(notify_peer),
    .notify_vector(notify_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic evt = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; local_event = evt;
    @(posedge clk); #1;
    wr_en = 1'b0; local_event = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, input logic evt = 1'b0);
    @(negedge clk);
    rd_en = 1'b1; addr = a; local_event = evt;
    @(posedge clk); #1;
    rd_en = 1'b0; local_event = 1'b0;
    d = rdata;
    chk("R5 rdata_valid", 32'(rdata_valid), 32'd1);
  endtask

  task automatic cfg_load(input int p, input int c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_peer = PEER_W'(p); cfg_count = CNT_W'(c);
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_event();
    @(negedge clk);
    local_event = 1'b1;
    @(posedge clk); #1;
    local_event = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata", rdata, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 notify_valid", 32'(notify_valid), 0);
    bus_rd(8'h00, v); chk("R1 mask", v, 0);
    bus_rd(8'h04, v); chk("R1 status", v, 0);
    bus_wr(8'h0C, 32'h0000_0000);
    chk("R1 counts zero, no notify", 32'(notify_valid), 0);
  endtask

  task automatic t_mask_status();
    logic [31:0] v;
    bus_wr(8'h00, 32'hA5A5_0F0F);
    bus_rd(8'h00, v); chk("R2 mask readback", v, 32'hA5A5_0F0F);
    bus_wr(8'h05, 32'h0000_1234);
    bus_rd(8'h04, v); chk("R2 status via unaligned write", v, 32'h0000_1234);
    bus_rd(8'h04, v); chk("R3 status cleared by read", v, 0);
    bus_wr(8'h03, 32'h0000_0077);
    bus_rd(8'h00, v); chk("R2 mask via offset 3", v, 32'h0000_0077);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    bus_wr(8'h00, 32'h3);
    bus_wr(8'h04, 32'h2);
    chk("R4 irq on", 32'(irq), 1);
    msi_mode = 1'b1; #1;
    chk("R4 irq off msi", 32'(irq), 0);
    msi_mode = 1'b0; pin_used = 1'b0; #1;
    chk("R4 irq off pin unused", 32'(irq), 0);
    pin_used = 1'b1; #1;
    chk("R4 irq back on", 32'(irq), 1);
    bus_wr(8'h00, 32'h4);
    chk("R4 irq masked", 32'(irq), 0);
    bus_wr(8'h00, 32'h2);
    chk("R4 irq unmasked", 32'(irq), 1);
    bus_rd(8'h04, v);
    chk("R3 read returns status", v, 32'h2);
    chk("R3 irq falls after read", 32'(irq), 0);
  endtask

  task automatic t_reads();
    logic [31:0] v;
    node_id = 16'h0ABC;
    bus_rd(8'h08, v); chk("R5 node id", v, 32'h0000_0ABC);
    bus_rd(8'h0C, v); chk("R5 doorbell reads zero", v, 0);
    bus_rd(8'h40, v); chk("R5 outside block", v, 0);
    bus_wr(8'h04, 32'h7);
    bus_rd(8'h05, v); chk("R5 unaligned read zero", v, 0);
    bus_rd(8'h04, v); chk("R5 unaligned read kept status", v, 32'h7);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] v;
    bus_wr(8'h00, 32'h11);
    bus_wr(8'h04, 32'h22);
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_wr(8'h80, 32'hFFFF_FFFF);
    bus_rd(8'h00, v); chk("R6 mask unchanged", v, 32'h11);
    bus_rd(8'h04, v); chk("R6 status unchanged", v, 32'h22);
    bus_rd(8'h08, v); chk("R6 node id unchanged", v, 32'h0000_0ABC);
  endtask

  task automatic t_doorbell();
    cfg_load(3, 4);
    cfg_load(15, 256);
    bus_wr(8'h0C, 32'h0003_0002);
    chk("R7 notify valid", 32'(notify_valid), 1);
    chk("R7 notify peer", 32'(notify_peer), 3);
    chk("R7 notify vector", 32'(notify_vector), 2);
    @(posedge clk); #1;
    chk("R7 single cycle pulse", 32'(notify_valid), 0);
    bus_wr(8'h0E, 32'h0003_FF03);
    chk("R7 bits 15:8 ignored, valid", 32'(notify_valid), 1);
    chk("R7 vector 3", 32'(notify_vector), 3);
    bus_wr(8'h0C, 32'h0003_0004);
    chk("R8 vector at count dropped", 32'(notify_valid), 0);
    bus_wr(8'h0C, 32'h0010_0000);
    chk("R8 peer out of range dropped", 32'(notify_valid), 0);
    bus_wr(8'h0C, 32'h0013_0000);
    chk("R8 aliasing peer dropped", 32'(notify_valid), 0);
    bus_wr(8'h0C, 32'h0005_0000);
    chk("R8 zero count dropped", 32'(notify_valid), 0);
    bus_wr(8'h0C, 32'h000F_00FF);
    chk("R8 count 256 accepts 255", 32'(notify_valid), 1);
    chk("R7 peer 15", 32'(notify_peer), 15);
    chk("R7 vector 255", 32'(notify_vector), 255);
  endtask

  task automatic t_event();
    logic [31:0] v;
    bus_wr(8'h04, 32'hF0);
    pulse_event();
    bus_rd(8'h04, v); chk("R9 event loads 1", v, 32'h1);
    msi_mode = 1'b1;
    bus_wr(8'h04, 32'h0);
    pulse_event();
    bus_rd(8'h04, v); chk("R9 event ignored in msi mode", v, 0);
    msi_mode = 1'b0;
    bus_wr(8'h04, 32'h55, 1'b1);
    bus_rd(8'h04, v); chk("R10 event beats write", v, 32'h1);
    bus_wr(8'h04, 32'h88);
    bus_rd(8'h04, v, 1'b1); chk("R10 read returns old value", v, 32'h88);
    bus_rd(8'h04, v); chk("R10 event beats read clear", v, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    node_id = 16'h0; msi_mode = 1'b0; pin_used = 1'b1; local_event = 1'b0;
    cfg_wr = 1'b0; cfg_peer = '0; cfg_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    t_reset();
    t_mask_status();
    t_irq();
    t_reads();
    t_ignored_writes();
    t_doorbell();
    t_event();
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule